// File: doc/BRIEF.md
# Flash Program Memory Write Controller

This block sits between a CPU register bus and an on-chip program flash array. Software programs it through three registers: a control register, an address register and a data register. From the control register it launches single-word reads, row erases and row programs on the array port. It also builds up a row of eight write latches one word at a time, so that a single program cycle can write the whole row.

Start bits in the control register can only be set by software. Hardware clears them when the array reports that the operation is complete. Program and erase requests are refused until a power-up hold counter expires after reset. They are also refused unless the write-enable bit is set in the same control write that sets the write-start bit. A configuration-space bit sends the access to the configuration and identification space instead of the main array.

The array port is a start/done handshake rather than a valid/ready stream. Only one operation is in flight at a time, and register writes are dropped while it runs. That is the block's only form of back-pressure. Software polls the start bits to learn when the block is idle again.

Top module: `flash_wr_ctrl`

## Requirements
- R1: After reset the control register reads 0x0080, the address and data registers read 0, no array operation is started, and every latch holds 0x3FFF (all ones).
- R2: Register select codes are 0 = control, 1 = address, 2 = data and 3 = reads 0. In the control view, bit 0 is write-enable, bit 1 is write-start, bit 2 is read-start, bit 3 is erase-select, bit 4 is latch-only and bit 5 is configuration-space. Bit 7 always reads 1, and bit 6 and bits 15:8 always read 0.
- R3: A control write that sets write-start (bit 1) without write-enable (bit 0) starts nothing, leaves write-start at 0 and leaves the latches unchanged.
- R4: Until PWRUP_CYCLES clock edges have passed since reset, every write-start is refused: write-start stays 0, no array operation starts and the latches stay unchanged.
- R5: An accepted program or erase holds write-start at 1 until the array signals done. Software cannot clear it. It reads 0 from the cycle after the done pulse.
- R6: Setting read-start (bit 2) with write-start at 0 launches a read with opcode 0, whatever the state of write-enable and the power-up counter. On done, the data register captures arr_rdata and read-start clears.
- R7: An accepted write-start with latch-only = 1 and erase-select = 0 copies the data register into latch address[2:0] and starts no array operation. Write-start reads back 0.
- R8: An accepted write-start with latch-only = 0 and erase-select = 0 loads the latch and then pulses arr_start for exactly one cycle, in the cycle after the write, with opcode 1. arr_wrow carries latch i in bits [14*i+13:14*i], including the word just loaded.
- R9: An accepted write-start with erase-select = 1 pulses arr_start with opcode 2 and leaves the latches untouched. Hardware clears erase-select and write-start after done.
- R10: arr_cfg follows the configuration-space bit, so an access with bit 5 = 1 goes to the configuration space.
- R11: While an operation is in flight, all register writes are ignored and no new arr_start occurs before done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 address, 2 data) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read view of the selected register |
| arr_start | output | 1 | One-cycle operation start to the array |
| arr_op | output | 2 | Opcode: 0 read, 1 program, 2 erase |
| arr_cfg | output | 1 | 1 selects the configuration space |
| arr_addr | output | 12 | Word address; upper bits name the row |
| arr_wrow | output | 112 | Latch row contents, latch i at bits [14*i +: 14] |
| arr_rdata | input | 14 | Read word from the array, valid with arr_done |
| arr_done | input | 1 | One-cycle completion pulse from the array |

## Verification
The assertions assume that the array raises arr_done once per start, for a single cycle, no earlier than the cycle after arr_start, and that arr_rdata is valid in that cycle. The bench's array stub counts a programmable delay of at least one cycle from each start it sees and then pulses done once. This means done never arrives while the block is idle or issuing. The register bus is driven only between clock edges, and writes sent during a busy window are deliberate probes of the drop rule.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } arr_op_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;

  // control view bit positions
  localparam int unsigned B_WEN   = 0;
  localparam int unsigned B_WR    = 1;
  localparam int unsigned B_RD    = 2;
  localparam int unsigned B_ERASE = 3;
  localparam int unsigned B_LATCH = 4;
  localparam int unsigned B_CFG   = 5;
  localparam int unsigned B_ZERO  = 6;
  localparam int unsigned B_ONE   = 7;
endpackage

// File: rtl/flash_wr_pwrup.sv
module flash_wr_pwrup #(
  parameter int unsigned HOLD_CYCLES = 1024000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == LIM);

  // R4: once open, the write window stays open until the next reset
  p_ready_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/flash_wr_latches.sv
module flash_wr_latches #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned DATA_W = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_en,
  input  logic [$clog2(WORDS)-1:0]  load_idx,
  input  logic [DATA_W-1:0]         load_data,
  output logic [WORDS*DATA_W-1:0]   row
);
  localparam int unsigned IDX_W = $clog2(WORDS);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      word_q <= '1;
      else if (load_en && (load_idx == IDX_W'(g)))     word_q <= load_data;
    end
    assign row[g*DATA_W +: DATA_W] = word_q;
  end

  // R3: without a load strobe no latch moves
  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(row));
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import flash_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [1:0] launch_op,
  input  logic       arr_done,
  output logic       arr_start,
  output logic [1:0] arr_op,
  output logic       busy,
  output logic       op_done
);
  seq_state_e state_q;
  logic [1:0] op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      op_q    <= OP_READ;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (launch) begin
          state_q <= SQ_ISSUE;
          op_q    <= launch_op;
        end
        SQ_ISSUE: state_q <= SQ_WAIT;
        SQ_WAIT:  if (arr_done) state_q <= SQ_IDLE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  assign arr_start = (state_q == SQ_ISSUE);
  assign arr_op    = op_q;
  assign busy      = (state_q != SQ_IDLE);
  assign op_done   = (state_q == SQ_WAIT) && arr_done;

  // R8: start is a single-cycle pulse followed by a wait
  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |=> !arr_start && busy);

  // R11: the register front end never launches into a busy sequencer
  p_launch_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
  import flash_wr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DATA_W       = 14,
  parameter int unsigned ROW_WORDS    = 8,
  parameter int unsigned REG_W        = 16,
  parameter int unsigned PWRUP_CYCLES = 1024000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [1:0]                  reg_sel,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  output logic                        arr_start,
  output logic [1:0]                  arr_op,
  output logic                        arr_cfg,
  output logic [ADDR_W-1:0]           arr_addr,
  output logic [ROW_WORDS*DATA_W-1:0] arr_wrow,
  input  logic [DATA_W-1:0]           arr_rdata,
  input  logic                        arr_done
);
  localparam int unsigned IDX_W = $clog2(ROW_WORDS);

  logic pu_ready, busy, op_done;
  logic wen_q, wr_go_q, rd_go_q, erase_q, latch_only_q, cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // register write decode; every write is dropped while busy
  logic ctrl_wr, addr_wr, data_wr;
  assign ctrl_wr = reg_we && !busy && (reg_sel == SEL_CTRL);
  assign addr_wr = reg_we && !busy && (reg_sel == SEL_ADDR);
  assign data_wr = reg_we && !busy && (reg_sel == SEL_DATA);

  logic wr_ok, do_erase, do_load, do_prog, do_read, launch;
  logic [1:0] launch_op;
  assign wr_ok     = ctrl_wr && reg_wdata[B_WR] && reg_wdata[B_WEN] && pu_ready;
  assign do_erase  = wr_ok && reg_wdata[B_ERASE];
  assign do_load   = wr_ok && !reg_wdata[B_ERASE];
  assign do_prog   = do_load && !reg_wdata[B_LATCH];
  assign do_read   = ctrl_wr && reg_wdata[B_RD] && !reg_wdata[B_WR];
  assign launch    = do_erase || do_prog || do_read;
  assign launch_op = do_erase ? OP_ERASE : (do_prog ? OP_PROG : OP_READ);

  flash_wr_pwrup #(.HOLD_CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk(clk), .rst_n(rst_n), .ready(pu_ready)
  );

  flash_wr_latches #(.WORDS(ROW_WORDS), .DATA_W(DATA_W)) u_latches (
    .clk(clk), .rst_n(rst_n),
    .load_en(do_load), .load_idx(addr_q[IDX_W-1:0]), .load_data(data_q),
    .row(arr_wrow)
  );

  flash_wr_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_op(launch_op), .arr_done(arr_done),
    .arr_start(arr_start), .arr_op(arr_op), .busy(busy), .op_done(op_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q        <= 1'b0;
      wr_go_q      <= 1'b0;
      rd_go_q      <= 1'b0;
      erase_q      <= 1'b0;
      latch_only_q <= 1'b0;
      cfg_q        <= 1'b0;
    end else if (ctrl_wr) begin
      wen_q        <= reg_wdata[B_WEN];
      erase_q      <= reg_wdata[B_ERASE];
      latch_only_q <= reg_wdata[B_LATCH];
      cfg_q        <= reg_wdata[B_CFG];
      wr_go_q      <= do_erase || do_prog;
      rd_go_q      <= do_read;
    end else if (op_done) begin
      unique case (arr_op)
        OP_ERASE: begin wr_go_q <= 1'b0; erase_q <= 1'b0; end
        OP_PROG:  wr_go_q <= 1'b0;
        default:  rd_go_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_wr) addr_q <= reg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               data_q <= '0;
    else if (data_wr)                         data_q <= reg_wdata[DATA_W-1:0];
    else if (op_done && arr_op == OP_READ)    data_q <= arr_rdata;
  end

  logic [7:0] ctrl_view;
  always_comb begin
    ctrl_view          = '0;
    ctrl_view[B_WEN]   = wen_q;
    ctrl_view[B_WR]    = wr_go_q;
    ctrl_view[B_RD]    = rd_go_q;
    ctrl_view[B_ERASE] = erase_q;
    ctrl_view[B_LATCH] = latch_only_q;
    ctrl_view[B_CFG]   = cfg_q;
    ctrl_view[B_ZERO]  = 1'b0;
    ctrl_view[B_ONE]   = 1'b1;
  end

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL: reg_rdata = REG_W'(ctrl_view);
      SEL_ADDR: reg_rdata = REG_W'(addr_q);
      SEL_DATA: reg_rdata = REG_W'(data_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign arr_addr = addr_q;
  assign arr_cfg  = cfg_q;

  // R5: write-start only falls through a completion
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go_q && !op_done |=> wr_go_q);

  // R3: a write-start that took effect was written together with write-enable
  p_wr_needs_wen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_go_q) |-> wen_q);

  // R4: no program or erase starts before the power-up window closes
  p_wr_after_pwrup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start && arr_op != OP_READ |-> pu_ready);

  // R9: completion of an erase drops erase-select and write-start
  p_erase_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && arr_op == OP_ERASE |=> !erase_q && !wr_go_q);

  // R6: a finished read leaves the array word in the data register
  p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && arr_op == OP_READ |=> !rd_go_q && data_q == $past(arr_rdata));

  // R11: address and space select are frozen while an operation runs
  p_busy_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q) && $stable(cfg_q));

  // R8: every start is owned by exactly one pending start bit
  p_start_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> (wr_go_q ^ rd_go_q));
endmodule

// File: tb/flash_wr_ctrl_tb.sv
module flash_wr_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int PU     = 16;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 14;
  localparam int WORDS  = 8;
  localparam int REG_W  = 16;
  localparam int ROW_W  = WORDS * DATA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic arr_start, arr_cfg;
  logic [1:0] arr_op;
  logic [ADDR_W-1:0] arr_addr;
  logic [ROW_W-1:0] arr_wrow;
  logic [DATA_W-1:0] arr_rdata = '0;
  logic arr_done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  flash_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_WORDS(WORDS),
                  .REG_W(REG_W), .PWRUP_CYCLES(PU)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_start(arr_start),
    .arr_op(arr_op), .arr_cfg(arr_cfg), .arr_addr(arr_addr),
    .arr_wrow(arr_wrow), .arr_rdata(arr_rdata), .arr_done(arr_done)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit stop_cmp = 1'b0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rfun(input int a, input bit c);
    logic [DATA_W-1:0] v;
    v = DATA_W'(a * 37 + 5);
    if (c) v = v ^ 14'h2A00;
    return v;
  endfunction

  // array stub
  int stub_delay = 2;
  int stub_cnt = 0;
  int starts = 0;
  int last_op = -1;
  int last_addr = 0;
  bit last_cfg = 1'b0;
  logic [ROW_W-1:0] last_row = '0;

  always @(negedge clk) begin
    arr_done = 1'b0;
    if (stub_cnt > 0) begin
      stub_cnt--;
      if (stub_cnt == 0) begin
        arr_done  = 1'b1;
        arr_rdata = rfun(last_addr, last_cfg);
      end
    end
    if (rst_n && arr_start) begin
      starts++;
      last_op   = int'(arr_op);
      last_addr = int'(arr_addr);
      last_cfg  = arr_cfg;
      last_row  = arr_wrow;
      stub_cnt  = stub_delay;
    end
  end

  // behavioural reference model, stepped on every rising edge
  int m_cnt = 0, m_phase = 0, m_op = 0, m_addr = 0, m_data = 0;
  bit m_wen = 0, m_wr = 0, m_rd = 0, m_er = 0, m_lo = 0, m_cfg = 0;
  int m_lat[WORDS];

  initial for (int i = 0; i < WORDS; i++) m_lat[i] = 16'h3FFF;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_op = 0; m_addr = 0; m_data = 0;
      m_wen = 0; m_wr = 0; m_rd = 0; m_er = 0; m_lo = 0; m_cfg = 0;
      for (int i = 0; i < WORDS; i++) m_lat[i] = 16'h3FFF;
    end else begin
      bit pu;
      pu = (m_cnt >= PU);
      if (m_cnt < PU) m_cnt++;
      if (m_phase == 1) m_phase = 2;
      else if (m_phase == 2) begin
        if (arr_done) begin
          if (m_op == 2) begin m_wr = 0; m_er = 0; end
          else if (m_op == 1) m_wr = 0;
          else begin m_rd = 0; m_data = int'(arr_rdata); end
          m_phase = 0;
        end
      end else if (reg_we) begin
        if (reg_sel == 2'd0) begin
          m_wen = reg_wdata[0]; m_er = reg_wdata[3];
          m_lo = reg_wdata[4]; m_cfg = reg_wdata[5];
          m_wr = 0; m_rd = 0;
          if (reg_wdata[1] && reg_wdata[0] && pu) begin
            if (reg_wdata[3]) begin m_op = 2; m_wr = 1; m_phase = 1; end
            else begin
              m_lat[m_addr % WORDS] = m_data;
              if (!reg_wdata[4]) begin m_op = 1; m_wr = 1; m_phase = 1; end
            end
          end else if (reg_wdata[2] && !reg_wdata[1]) begin
            m_op = 0; m_rd = 1; m_phase = 1;
          end
        end else if (reg_sel == 2'd1) m_addr = int'(reg_wdata) % (1 << ADDR_W);
        else if (reg_sel == 2'd2) m_data = int'(reg_wdata) % (1 << DATA_W);
      end
    end
  end

  function automatic logic [ROW_W-1:0] m_row();
    logic [ROW_W-1:0] r;
    for (int i = 0; i < WORDS; i++) r[i*DATA_W +: DATA_W] = DATA_W'(m_lat[i]);
    return r;
  endfunction

  function automatic logic [REG_W-1:0] m_view(input logic [1:0] s);
    case (s)
      2'd0: return {8'h00, 1'b1, 1'b0, m_cfg, m_lo, m_er, m_rd, m_wr, m_wen};
      2'd1: return REG_W'(m_addr);
      2'd2: return REG_W'(m_data);
      default: return '0;
    endcase
  endfunction

  // per-cycle comparison, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n && !stop_cmp) begin
      chk("R8 start timing", 128'(arr_start), 128'(m_phase == 1));
      if (m_phase == 1) chk("R8 opcode", 128'(arr_op), 128'(m_op));
      chk("R11 address", 128'(arr_addr), 128'(m_addr));
      chk("R10 space select", 128'(arr_cfg), 128'(m_cfg));
      chk("R7 latch row", 128'(arr_wrow), 128'(m_row()));
      chk("R2 register view", 128'(reg_rdata), 128'(m_view(reg_sel)));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    reg_sel = s;
    #(CLK_P/4);
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 200; k++) begin
      rd(2'd0, v);
      if (v[2:1] == 2'b00) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    stop_cmp = 1'b1;
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=idle");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [ROW_W-1:0] exp_row;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl reset", 128'(v), 128'(16'h0080));
    rd(2'd1, v); chk("R1 addr reset", 128'(v), 128'(0));
    rd(2'd2, v); chk("R1 data reset", 128'(v), 128'(0));
    chk("R1 latches reset", 128'(arr_wrow), 128'({ROW_W{1'b1}}));
    rd(2'd3, v); chk("R2 unused select", 128'(v), 128'(0));

    // R4 refused before power-up window closes
    wr(2'd1, 16'h0045);
    wr(2'd2, 16'h1234);
    wr(2'd0, 16'h0003);
    rd(2'd0, v); chk("R4 early start refused", 128'(v), 128'(16'h0081));
    chk("R4 no array start", 128'(starts), 128'(0));
    chk("R4 latches untouched", 128'(arr_wrow), 128'({ROW_W{1'b1}}));

    repeat (PU) @(negedge clk);

    // R3 write-start without write-enable
    wr(2'd0, 16'h0002);
    rd(2'd0, v); chk("R3 start without enable", 128'(v), 128'(16'h0080));
    chk("R3 no array start", 128'(starts), 128'(0));
    chk("R3 latches untouched", 128'(arr_wrow), 128'({ROW_W{1'b1}}));

    // R7 latch-only fill of the whole row
    for (int i = 0; i < WORDS; i++) begin
      wr(2'd1, 16'(16'h0040 + i));
      wr(2'd2, 16'(16'h0100 + 3 * i));
      wr(2'd0, 16'h0013);
    end
    rd(2'd0, v); chk("R7 start reads 0", 128'(v), 128'(16'h0091));
    chk("R7 no array start", 128'(starts), 128'(0));
    for (int i = 0; i < WORDS; i++) exp_row[i*DATA_W +: DATA_W] = DATA_W'(16'h0100 + 3 * i);
    chk("R7 latch contents", 128'(arr_wrow), 128'(exp_row));

    // R8 program, R5 hold, R11 drop while busy
    stub_delay = 6;
    wr(2'd1, 16'h0045);
    wr(2'd2, 16'h2AAA);
    wr(2'd0, 16'h0003);
    #(CLK_P/4);
    chk("R8 start next cycle", 128'(arr_start), 128'(1));
    wr(2'd1, 16'h07FF);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R5 start not clearable", 128'(v), 128'(16'h0083));
    rd(2'd1, v); chk("R11 addr write dropped", 128'(v), 128'(16'h0045));
    wait_idle();
    rd(2'd0, v); chk("R5 cleared after done", 128'(v), 128'(16'h0081));
    chk("R11 single start", 128'(starts), 128'(1));
    chk("R8 program opcode", 128'(last_op), 128'(1));
    exp_row[5*DATA_W +: DATA_W] = 14'h2AAA;
    chk("R8 row carries new word", 128'(last_row), 128'(exp_row));
    chk("R8 row address", 128'(last_addr), 128'(16'h0045));

    // R9 erase
    stub_delay = 3;
    wr(2'd0, 16'h000B);
    rd(2'd0, v); chk("R9 erase pending", 128'(v), 128'(16'h008B));
    wait_idle();
    rd(2'd0, v); chk("R9 erase bit cleared", 128'(v), 128'(16'h0081));
    chk("R9 erase opcode", 128'(last_op), 128'(2));
    chk("R9 latches untouched", 128'(arr_wrow), 128'(exp_row));

    // R6 read with write-enable off
    stub_delay = 2;
    wr(2'd1, 16'h0021);
    wr(2'd0, 16'h0004);
    wait_idle();
    rd(2'd2, v); chk("R6 read data", 128'(v), 128'(rfun(16'h21, 1'b0)));
    rd(2'd0, v); chk("R6 read-start cleared", 128'(v), 128'(16'h0080));
    chk("R6 read opcode", 128'(last_op), 128'(0));

    // R10 configuration space read
    stub_delay = 4;
    wr(2'd0, 16'h0024);
    wait_idle();
    chk("R10 cfg routed", 128'(last_cfg), 128'(1));
    rd(2'd2, v); chk("R10 cfg read data", 128'(v), 128'(rfun(16'h21, 1'b1)));
    rd(2'd0, v); chk("R10 ctrl view", 128'(v), 128'(16'h00A0));

    repeat (3) @(negedge clk);
    stop_cmp = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule